// File: doc/BRIEF.md
# Multi-Key Combo Hold Detector

This block watches five active-low user inputs: three keyboard lines, a power button and an AC-present line. It runs four independent combo channels. Each channel holds three settings. A select mask names the inputs that make up the combo. A 32-bit hold count gives the hold time in slow ticks. An action mask chooses what happens when the combo has been held long enough. Before any channel sees the inputs, each one passes through its own polarity flip, which is controlled by an invert mask.

A channel arms when every input it selects reads low after the polarity flip. Its timer then advances once on each cycle where the 200 kHz tick enable is high. When the count reaches the programmed hold value, the channel fires once. It sets a sticky status bit, which software clears by writing 1 to it, and it raises the actions it has enabled. Two of these actions are one-cycle reset requests, one for the controller and one for the security chip. The battery-disable action is a level that stays high until block reset. The interrupt actions of all channels are combined into one request line. A lock bit, which can only be cleared, freezes the channel configuration until the next reset.

Top module: `combo_hold_detector`

## Requirements
- R1: After reset, status is 0, comboIrq, batDisable, ecRstReq and gscRstReq are 0, and every channel has an empty select mask, a hold value of 0 and an empty action mask.
- R2: Select mask bit 0 is key0, bit 1 is key1, bit 2 is key2, bit 3 is the power button and bit 4 is AC present; a channel fires when all its selected inputs have been low for hold+1 clock cycles with tickEn high throughout (hold 0 fires on the first cycle the combo is seen).
- R3: If a selected input goes high before the channel fires, its timer restarts from zero at the next press.
- R4: A held combo fires only once; it fires again only after it is released and pressed again.
- R5: A channel whose select mask is all zero never fires and raises no action.
- R6: Inputs that a channel does not select have no effect on that channel.
- R7: Each input is XORed with its invMask bit before the combo logic, so a set bit turns a high pin into an active level.
- R8: Action mask bit 2 (controller reset) and bit 3 (security-chip reset) give a one-cycle high pulse on ecRstReq or gscRstReq in the same cycle the status bit first reads 1.
- R9: Action mask bit 0 (battery disable) sets batDisable, which stays high until block reset.
- R10: comboIrq is high while any channel has its status bit set and action mask bit 1 (interrupt) enabled.
- R11: clrWe with clrMask clears the status bits where the mask is 1; if a fire and a clear hit the same bit in the same cycle, the fire wins.
- R12: lockWe with lockData 0 locks the configuration, after which cfgWe writes are ignored until reset; lockWe with lockData 1 has no effect.
- R13: A channel's timer advances only in cycles where tickEn is high.
- R14: The four channels time and fire independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Slow timebase enable, one cycle per hold step |
| rawIn | input | 5 | Input pin levels: key0, key1, key2, power button, AC present |
| invMask | input | 5 | Per-input polarity flip |
| cfgWe | input | 1 | Configuration write strobe |
| cfgChan | input | 2 | Channel addressed by the write |
| cfgSel | input | 5 | Select mask to write |
| cfgHold | input | 32 | Hold count to write |
| cfgAct | input | 4 | Action mask to write |
| lockWe | input | 1 | Lock write strobe |
| lockData | input | 1 | Lock write value (0 locks) |
| clrWe | input | 1 | Status clear strobe |
| clrMask | input | 4 | Status bits to clear |
| status | output | 4 | Sticky per-channel fired flags |
| comboIrq | output | 1 | Combined interrupt request |
| batDisable | output | 1 | Latched battery-disable request |
| ecRstReq | output | 1 | Controller reset request pulse |
| gscRstReq | output | 1 | Security-chip reset request pulse |

## Verification
The bench sweeps the hold value over several small settings and counts the exact cycle of firing. A design that was off by one in its compare or in its arm cycle would fire one cycle early or late. It releases the combo partway through the hold and re-presses it, and keeps a fired combo held after clearing its status. A design that kept a stale count would fire early, and one without a fired flag would refire. It toggles unselected inputs while a combo is held, presses with the tick gated off, and drives the AC line through the polarity flip; a design that leaked unselected inputs or ignored the tick gate would then fire when it should not. It also checks that writes are dropped after the lock and that writing 1 to the lock does not unlock it. It runs two channels with different hold values at once and checks every cycle, which catches shared timers and reset pulses that last longer than one cycle.

// File: rtl/combo_pkg.sv
package combo_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_IN  = 5;
  localparam int HOLD_W  = 32;
  localparam int NUM_ACT = 4;
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // action mask bit positions
  localparam int ACT_BAT = 0;
  localparam int ACT_IRQ = 1;
  localparam int ACT_EC  = 2;
  localparam int ACT_GSC = 3;

  typedef struct packed {
    logic [NUM_CH-1:0] cntClr;
    logic [NUM_CH-1:0] cntInc;
    logic              cfgLoad;
  } ctl_strobe_t;
endpackage

// File: rtl/combo_datapath.sv
module combo_datapath import combo_pkg::*; (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_IN-1:0]                rawIn,
  input  logic [NUM_IN-1:0]                invMask,
  input  logic [CH_W-1:0]                  cfgChan,
  input  logic [NUM_IN-1:0]                cfgSel,
  input  logic [HOLD_W-1:0]                cfgHold,
  input  logic [NUM_ACT-1:0]               cfgAct,
  input  ctl_strobe_t                      strobe,
  output logic [NUM_CH-1:0]                active,
  output logic [NUM_CH-1:0]                expired,
  output logic [NUM_CH-1:0][NUM_ACT-1:0]   actMask
);
  logic [NUM_IN-1:0] levelFixed;
  assign levelFixed = rawIn ^ invMask;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_IN-1:0]  selReg;
    logic [HOLD_W-1:0]  holdReg;
    logic [HOLD_W-1:0]  cnt;
    logic [NUM_ACT-1:0] actReg;
    logic               wrHit;

    assign wrHit = strobe.cfgLoad && (cfgChan == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg  <= '0;
        holdReg <= '0;
        actReg  <= '0;
      end else if (wrHit) begin
        selReg  <= cfgSel;
        holdReg <= cfgHold;
        actReg  <= cfgAct;
      end
    end

    // hold timer, saturating at all ones
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             cnt <= '0;
      else if (strobe.cntClr[c])             cnt <= '0;
      else if (strobe.cntInc[c] && cnt != '1) cnt <= cnt + 1'b1;
    end

    assign active[c]  = (selReg != '0) && ((levelFixed & selReg) == '0);
    assign expired[c] = active[c] && (cnt >= holdReg);
    assign actMask[c] = actReg;
  end
endmodule

// File: rtl/combo_control.sv
module combo_control import combo_pkg::*; (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tickEn,
  input  logic                             cfgWe,
  input  logic                             lockWe,
  input  logic                             lockData,
  input  logic                             clrWe,
  input  logic [NUM_CH-1:0]                clrMask,
  input  logic [NUM_CH-1:0]                active,
  input  logic [NUM_CH-1:0]                expired,
  input  logic [NUM_CH-1:0][NUM_ACT-1:0]   actMask,
  output ctl_strobe_t                      strobe,
  output logic [NUM_CH-1:0]                status,
  output logic                             comboIrq,
  output logic                             batDisable,
  output logic                             ecRstReq,
  output logic                             gscRstReq
);
  logic              unlocked;
  logic [NUM_CH-1:0] fired;
  logic [NUM_CH-1:0] fire;
  logic [NUM_CH-1:0] irqEn;
  logic              batHit, ecHit, gscHit;

  assign fire = expired & ~fired;

  always_comb begin
    strobe.cfgLoad = cfgWe & unlocked;
    strobe.cntClr  = ~active;
    strobe.cntInc  = active & ~fired & {NUM_CH{tickEn}};
  end

  always_comb begin
    batHit = 1'b0;
    ecHit  = 1'b0;
    gscHit = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      irqEn[c] = actMask[c][ACT_IRQ];
      if (fire[c]) begin
        batHit = batHit | actMask[c][ACT_BAT];
        ecHit  = ecHit  | actMask[c][ACT_EC];
        gscHit = gscHit | actMask[c][ACT_GSC];
      end
    end
  end

  assign comboIrq = |(status & irqEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked   <= 1'b1;
      fired      <= '0;
      status     <= '0;
      batDisable <= 1'b0;
      ecRstReq   <= 1'b0;
      gscRstReq  <= 1'b0;
    end else begin
      if (lockWe && !lockData) unlocked <= 1'b0;
      fired      <= (fired | fire) & active;
      status     <= (status & ~(clrWe ? clrMask : '0)) | fire;
      batDisable <= batDisable | batHit;
      ecRstReq   <= ecHit;
      gscRstReq  <= gscHit;
    end
  end
endmodule

// File: rtl/combo_hold_detector.sv
module combo_hold_detector import combo_pkg::*; (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [NUM_IN-1:0]   rawIn,
  input  logic [NUM_IN-1:0]   invMask,
  input  logic                cfgWe,
  input  logic [CH_W-1:0]     cfgChan,
  input  logic [NUM_IN-1:0]   cfgSel,
  input  logic [HOLD_W-1:0]   cfgHold,
  input  logic [NUM_ACT-1:0]  cfgAct,
  input  logic                lockWe,
  input  logic                lockData,
  input  logic                clrWe,
  input  logic [NUM_CH-1:0]   clrMask,
  output logic [NUM_CH-1:0]   status,
  output logic                comboIrq,
  output logic                batDisable,
  output logic                ecRstReq,
  output logic                gscRstReq
);
  ctl_strobe_t                    ctlStrobe;
  logic [NUM_CH-1:0]              chActive;
  logic [NUM_CH-1:0]              chExpired;
  logic [NUM_CH-1:0][NUM_ACT-1:0] chAct;

  combo_datapath u_dp (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .invMask(invMask),
    .cfgChan(cfgChan), .cfgSel(cfgSel), .cfgHold(cfgHold), .cfgAct(cfgAct),
    .strobe(ctlStrobe), .active(chActive), .expired(chExpired), .actMask(chAct)
  );

  combo_control u_ctl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cfgWe(cfgWe),
    .lockWe(lockWe), .lockData(lockData), .clrWe(clrWe), .clrMask(clrMask),
    .active(chActive), .expired(chExpired), .actMask(chAct),
    .strobe(ctlStrobe), .status(status), .comboIrq(comboIrq),
    .batDisable(batDisable), .ecRstReq(ecRstReq), .gscRstReq(gscRstReq)
  );
endmodule

// File: rtl/combo_hold_checker.sv
module combo_hold_checker import combo_pkg::*; (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] active,
  input logic [NUM_CH-1:0] cntInc,
  input logic              comboIrq,
  input logic              batDisable,
  input logic              ecRstReq,
  input logic              gscRstReq
);
  p_bat_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    batDisable |=> batDisable);

  p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (!rstN)
    comboIrq |-> (status != '0));

  p_rise_needs_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~$past(status)) != '0) |-> ((status & ~$past(status) & ~$past(active)) == '0));

  p_ec_needs_active_r8: assert property (@(posedge clk) disable iff (!rstN)
    ecRstReq |-> ($past(active) != '0));

  p_gsc_needs_active_r8: assert property (@(posedge clk) disable iff (!rstN)
    gscRstReq |-> ($past(active) != '0));

  p_tick_gate_r13: assert property (@(posedge clk) disable iff (!rstN)
    (cntInc != '0) |-> tickEn);

  p_idle_no_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((cntInc & ~active) == '0));
endmodule

bind combo_hold_detector combo_hold_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .status(status),
  .active(chActive), .cntInc(ctlStrobe.cntInc), .comboIrq(comboIrq),
  .batDisable(batDisable), .ecRstReq(ecRstReq), .gscRstReq(gscRstReq)
);

// File: tb/tb_combo_hold_detector.sv
module tb_combo_hold_detector;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic [4:0] rawIn = 5'h1F;
  logic [4:0] invMask = '0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgChan = '0;
  logic [4:0] cfgSel = '0;
  logic [31:0] cfgHold = '0;
  logic [3:0] cfgAct = '0;
  logic lockWe = 1'b0, lockData = 1'b0, clrWe = 1'b0;
  logic [3:0] clrMask = '0;
  logic [3:0] status;
  logic comboIrq, batDisable, ecRstReq, gscRstReq;

  int nChecks = 0;
  int nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_hold_detector dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rawIn(rawIn), .invMask(invMask),
    .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgSel(cfgSel), .cfgHold(cfgHold),
    .cfgAct(cfgAct), .lockWe(lockWe), .lockData(lockData), .clrWe(clrWe),
    .clrMask(clrMask), .status(status), .comboIrq(comboIrq),
    .batDisable(batDisable), .ecRstReq(ecRstReq), .gscRstReq(gscRstReq)
  );

  task automatic chk(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCfg(int ch, logic [4:0] sel, logic [31:0] hold, logic [3:0] act);
    cfgWe = 1'b1; cfgChan = ch[1:0]; cfgSel = sel; cfgHold = hold; cfgAct = act;
    cycle();
    cfgWe = 1'b0;
  endtask

  task automatic clearAll();
    clrWe = 1'b1; clrMask = 4'hF;
    cycle();
    clrWe = 1'b0;
  endtask

  task automatic writeLock(logic v);
    lockWe = 1'b1; lockData = v;
    cycle();
    lockWe = 1'b0;
  endtask

  task automatic waitFire(int ch, int limit, output int n, output logic ec, output logic gsc);
    n = 0; ec = 1'b0; gsc = 1'b0;
    while (n < limit) begin
      cycle();
      n++;
      if (status[ch]) begin
        ec = ecRstReq; gsc = gscRstReq;
        break;
      end
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    int n;
    logic ec, gsc;
    @(negedge clk);
    repeat (3) cycle();
    rstN = 1'b1;
    cycle();
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 comboIrq", comboIrq, 0);
    chk("R1 batDisable", batDisable, 0);
    chk("R1 ecRstReq", ecRstReq, 0);
    chk("R1 gscRstReq", gscRstReq, 0);

    // R2/R8/R10/R11 sweep of hold values, combo key0+key1+pwrb
    for (int h = 0; h <= 6; h++) begin
      writeCfg(0, 5'b01011, h, 4'b0110);
      rawIn = 5'b10100;
      waitFire(0, 40, n, ec, gsc);
      chk("R2 fire cycle", n, h + 1);
      chk("R8 ec pulse high", ec, 1);
      chk("R10 irq with status", comboIrq, 1);
      cycle();
      chk("R8 ec pulse one cycle", ecRstReq, 0);
      clearAll();
      chk("R11 status cleared", status[0], 0);
      chk("R10 irq after clear", comboIrq, 0);
      rawIn = 5'h1F;
      cycle();
    end

    // R4 fire once per press
    writeCfg(0, 5'b01011, 3, 4'b0110);
    rawIn = 5'b10100;
    waitFire(0, 40, n, ec, gsc);
    chk("R4 first press", n, 4);
    clearAll();
    repeat (10) cycle();
    chk("R4 no refire while held", status[0], 0);
    rawIn = 5'h1F;
    cycle();
    rawIn = 5'b10100;
    waitFire(0, 40, n, ec, gsc);
    chk("R4 second press", n, 4);
    rawIn = 5'h1F;
    clearAll();

    // R3 release before expiry restarts timer
    writeCfg(0, 5'b01011, 8, 4'b0110);
    rawIn = 5'b10100;
    repeat (5) cycle();
    rawIn = 5'h1F;
    cycle();
    chk("R3 no early fire", status[0], 0);
    rawIn = 5'b10100;
    waitFire(0, 40, n, ec, gsc);
    chk("R3 restart count", n, 9);
    rawIn = 5'h1F;
    clearAll();

    // R6 unselected inputs ignored
    writeCfg(0, 5'b00001, 2, 4'b0110);
    rawIn = 5'b11011;
    repeat (15) cycle();
    chk("R6 unselected press", status[0], 0);
    rawIn = 5'b11110;
    cycle();
    rawIn[4:1] = rawIn[4:1] ^ 4'hF;
    cycle();
    rawIn[4:1] = rawIn[4:1] ^ 4'hF;
    chk("R6 not yet", status[0], 0);
    cycle();
    chk("R6 fires despite toggles", status[0], 1);
    rawIn = 5'h1F;
    clearAll();

    // R5 empty select never fires
    writeCfg(1, 5'b00000, 0, 4'b0001);
    rawIn = 5'h00;
    repeat (20) cycle();
    chk("R5 empty mask status", status[1], 0);
    chk("R5 empty mask bat", batDisable, 0);
    rawIn = 5'h1F;
    cycle();
    clearAll();

    // R7 polarity flip on AC present (bit 4)
    writeCfg(0, 5'b10000, 2, 4'b0110);
    invMask = 5'b10000;
    waitFire(0, 40, n, ec, gsc);
    chk("R7 inverted input fires", n, 3);
    invMask = 5'b00000;
    cycle();
    clearAll();

    // R13 tick gating
    writeCfg(0, 5'b00001, 2, 4'b0110);
    tickEn = 1'b0;
    rawIn = 5'b11110;
    repeat (20) cycle();
    chk("R13 no tick no fire", status[0], 0);
    tickEn = 1'b1;
    waitFire(0, 40, n, ec, gsc);
    chk("R13 fires after ticks", n, 3);
    rawIn = 5'h1F;
    cycle();
    clearAll();

    // R14/R8/R9 two channels in parallel: ch2 pwrb hold 3 gsc, ch3 ac hold 6 bat
    writeCfg(2, 5'b01000, 3, 4'b1000);
    writeCfg(3, 5'b10000, 6, 4'b0001);
    rawIn = 5'b00111;
    for (int t = 1; t <= 8; t++) begin
      cycle();
      chk("R14 ch2 status", status[2], (t >= 4) ? 1 : 0);
      chk("R14 ch3 status", status[3], (t >= 7) ? 1 : 0);
      chk("R8 gsc pulse", gscRstReq, (t == 4) ? 1 : 0);
      chk("R9 bat level", batDisable, (t >= 7) ? 1 : 0);
    end
    rawIn = 5'h1F;
    clearAll();
    repeat (5) cycle();
    chk("R9 bat stays high", batDisable, 1);

    // R12 lock
    writeLock(1'b1);
    writeCfg(0, 5'b00001, 1, 4'b0110);
    rawIn = 5'b11110;
    waitFire(0, 40, n, ec, gsc);
    chk("R12 writing 1 does not lock", n, 2);
    rawIn = 5'h1F;
    cycle();
    clearAll();
    writeLock(1'b0);
    writeCfg(0, 5'b00001, 9, 4'b0110);
    rawIn = 5'b11110;
    waitFire(0, 40, n, ec, gsc);
    chk("R12 write ignored when locked", n, 2);
    rawIn = 5'h1F;
    cycle();
    clearAll();
    writeLock(1'b1);
    writeCfg(0, 5'b00001, 9, 4'b0110);
    rawIn = 5'b11110;
    waitFire(0, 40, n, ec, gsc);
    chk("R12 lock not reopened", n, 2);
    rawIn = 5'h1F;
    cycle();

    // R1/R9 block reset clears latch and configuration
    rstN = 1'b0;
    cycle();
    rstN = 1'b1;
    cycle();
    chk("R9 bat cleared by reset", batDisable, 0);
    chk("R1 status after reset", status, 0);
    rawIn = 5'h00;
    repeat (10) cycle();
    chk("R1 default config inert", status, 0);
    rawIn = 5'h1F;
    cycle();
    finishRun();
  end
endmodule